// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the sequence of column addresses a synchronous DRAM burst walks through. A controller presents a start column together with a one-cycle start strobe. On the next clock the generator begins presenting one column per clock on its output, together with a valid flag. It raises a last flag on the final beat of a fixed-length burst so that downstream logic can line up the next command.

The burst length and beat ordering come from mode fields that the block captures at the start strobe only. The fixed lengths are 1, 2, 4 and 8 beats. In a fixed burst the beats stay inside the naturally aligned window of that length that holds the start column. The beat ordering is either an upward count that wraps inside the window, or an XOR of the beat number into the low column bits. A full-page length instead walks every column of the row, wrapping from the top column to column zero. It keeps going until a stop strobe or a new start.

A stop strobe ends the burst at any length. A fresh start strobe abandons any burst in flight and restarts from the new column, so column commands can be issued on every clock.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, valid_o and last_o are 0 and col_o is 0 until the first start strobe.
- R2: A start_i sampled high at a rising edge makes valid_o high from that edge on, with col_o equal to the sampled start_col_i as beat 0. One further beat follows per clock, and a start on every clock gives a new beat 0 on every clock.
- R3: Length code mode_len_i selects the burst length: code k from 0 to 3 gives 2^k beats, and code 7 gives full page. Once the final beat of a fixed burst has been shown, valid_o falls on the next clock unless start_i is high at that edge.
- R4: With mode_ilv_i = 0 (sequential), beat n of a length-BL burst carries the upper column bits of the start column unchanged. Its low log2(BL) bits equal (start low bits + n) mod BL.
- R5: With mode_ilv_i = 1 (interleave), beat n of a length-BL burst carries the upper column bits unchanged. Its low log2(BL) bits equal the start low bits XOR n.
- R6: A full-page burst (code 7) presents start_col + n mod 512 on beat n, whatever mode_ilv_i holds. It never raises last_o.
- R7: last_o is high exactly on the final beat of a fixed burst, which for length 1 is beat 0, and only while valid_o is high.
- R8: stop_i high at an edge while a burst runs and start_i is low makes valid_o low after that edge. stop_i while idle has no effect, so the outputs stay at valid 0 and column 0.
- R9: A start arriving mid-burst restarts from the new column on the next clock. When start_i and stop_i are both high, the start wins.
- R10: mode_len_i and mode_ilv_i are sampled only with start_i, so changing them during a burst does not alter that burst.
- R11: While valid_o is low, col_o reads 0.
- R12: The unused length codes 4, 5 and 6 each give a single-beat burst with last_o on beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_len_i | input | 3 | Burst length code (0..3: 2^code beats, 7: full page, 4..6: one beat) |
| mode_ilv_i | input | 1 | Beat ordering: 0 sequential, 1 interleave |
| start_i | input | 1 | Start a burst at start_col_i |
| stop_i | input | 1 | End the running burst |
| start_col_i | input | 9 | First column of the burst |
| col_o | output | 9 | Column address of the current beat, 0 when idle |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Assertions check several things on every clock: the load of a new start column, the drop of valid after a last beat or a stop, and last never showing without valid. They also check that the column bits above the burst window hold still during a burst, that a full page steps by exactly one column, and that the beat counter stays inside its window. Only the bench's scenarios can show the exact beat orderings for each length and type. The same holds for the unused length codes, for mode changes made mid-burst being ignored, and for the start-over-stop priority, all of which the bench's reference model compares beat by beat.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } beat_order_e;

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg #(
   parameter int COL_W     = 9,
   parameter int LEN_W     = 3,
   parameter int FIX_CODES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] mask_o,
   output logic             full_o,
   output logic             ilv_o
);
   import colgen_pkg::*;

   localparam logic [LEN_W-1:0] FULL_CODE = '1;
   localparam logic [LEN_W-1:0] FIX_LIM   = LEN_W'(FIX_CODES);

   logic [LEN_W-1:0] len_q;
   beat_order_e      ord_q;
   logic [LEN_W-1:0] lg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         ord_q <= ORD_SEQ;
      end else if (load_i) begin
         len_q <= len_i;
         ord_q <= beat_order_e'(ilv_i);
      end
   end

   assign full_o = (len_q == FULL_CODE);
   // R12: codes outside the fixed range fall back to one beat
   assign lg     = (len_q < FIX_LIM) ? len_q : '0;
   // R6: full page always counts upward
   assign ilv_o  = (ord_q == ORD_ILV) & ~full_o;

   for (genvar j = 0; j < COL_W; j++) begin : g_mask
      assign mask_o[j] = full_o | ({{(32-LEN_W){1'b0}}, lg} > 32'(j));
   end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   output logic             run_o,
   output logic [COL_W-1:0] beat_o,
   output logic             last_o
);
   logic             run_q;
   logic [COL_W-1:0] beat_q;

   assign last_o = run_q & ~full_i & (beat_q == mask_i);
   assign run_o  = run_q;
   assign beat_o = beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         beat_q <= '0;
      end else if (start_i) begin
         run_q  <= 1'b1;
         beat_q <= '0;
      end else if (run_q) begin
         if (stop_i || last_o) begin
            run_q  <= 1'b0;
            beat_q <= '0;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   // R3
   beat_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !full_i) |-> ((beat_q & ~mask_i) == '0));

   // R8
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && stop_i && !start_i) |=> !run_q);

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic             run_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_q <= '0;
      else if (load_i)
         base_q <= start_col_i;
   end

   assign sum = base_q + beat_i;

   for (genvar j = 0; j < COL_W; j++) begin : g_bit
      assign col_o[j] = run_i & (mask_i[j] ? (ilv_i ? (base_q[j] ^ beat_i[j]) : sum[j])
                                           : base_q[j]);
   end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
   parameter int COL_W     = 9,
   parameter int LEN_W     = 3,
   parameter int FIX_CODES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] mode_len_i,
   input  logic             mode_ilv_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] start_col_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   localparam int MAX_LG = FIX_CODES - 1;

   initial begin : param_chk
      assert (MAX_LG < COL_W)
         else $error("largest fixed burst must fit in the column width");
      assert (FIX_CODES >= 1 && FIX_CODES < (1 << LEN_W))
         else $error("fixed length codes must leave room for the full-page code");
   end

   logic [COL_W-1:0] mask_q;
   logic             full_q;
   logic             ilv_q;
   logic             run;
   logic [COL_W-1:0] beat;

   colgen_mode_reg #(.COL_W(COL_W), .LEN_W(LEN_W), .FIX_CODES(FIX_CODES)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_i),
      .len_i  (mode_len_i),
      .ilv_i  (mode_ilv_i),
      .mask_o (mask_q),
      .full_o (full_q),
      .ilv_o  (ilv_q)
   );

   colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .stop_i  (stop_i),
      .mask_i  (mask_q),
      .full_i  (full_q),
      .run_o   (run),
      .beat_o  (beat),
      .last_o  (last_o)
   );

   colgen_addr_map #(.COL_W(COL_W)) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (start_i),
      .start_col_i (start_col_i),
      .run_i       (run),
      .beat_i      (beat),
      .mask_i      (mask_q),
      .ilv_i       (ilv_q),
      .col_o       (col_o)
   );

   assign valid_o = run;

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   // R7
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R3
   end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   // R6
   fullpage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && full_q && !start_i && !stop_i) |=> (col_o == $past(col_o) + 1'b1));

   // R4
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !start_i && !stop_i && !last_o) |=>
         (((col_o ^ $past(col_o)) & ~mask_q) == '0));

endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] len = 3'd0;
   logic       ilv = 1'b0;
   logic       start = 1'b0;
   logic       stop = 1'b0;
   logic [8:0] scol = 9'd0;
   logic [8:0] col;
   logic       valid;
   logic       last;

   int    checks = 0;
   int    failures = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_run = 0, m_base = 0, m_beat = 0, m_len = 0, m_ilv = 0;

   sdram_burst_colgen dut (
      .clk(clk), .rst_n(rst_n), .mode_len_i(len), .mode_ilv_i(ilv),
      .start_i(start), .stop_i(stop), .start_col_i(scol),
      .col_o(col), .valid_o(valid), .last_o(last)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int bl_of(int code);
      if (code == 7) return 512;
      if (code < 4)  return 1 << code;
      return 1;
   endfunction

   function automatic int exp_col();
      int bl, lo, hi;
      if (m_run == 0) return 0;
      if (m_len == 7) return (m_base + m_beat) % 512;
      bl = bl_of(m_len);
      lo = m_base % bl;
      hi = m_base - lo;
      if (m_ilv != 0) return hi + (lo ^ m_beat);
      return hi + ((lo + m_beat) % bl);
   endfunction

   function automatic bit exp_last();
      return (m_run != 0) && (m_len != 7) && (m_beat == bl_of(m_len) - 1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_beat = 0;
      end else if (start) begin
         m_run = 1; m_base = int'(scol); m_beat = 0;
         m_len = int'(len); m_ilv = int'(ilv);
      end else if (m_run != 0) begin
         if (stop || exp_last()) begin
            m_run = 0; m_beat = 0;
         end else begin
            m_beat = (m_beat + 1) % 512;
         end
      end
   end

   task automatic cyc();
      int ec;
      bit ev, el;
      @(negedge clk);
      ec = exp_col();
      ev = (m_run != 0);
      el = exp_last();
      checks++;
      if (int'(col) != ec || valid != ev || last != el) begin
         failures++;
         $display("FAIL %s col=%h/%h valid=%b/%b last=%b/%b (actual/expected)",
                  cur_req, col, ec[8:0], valid, ev, last, el);
      end
   endtask

   task automatic idle(int n);
      repeat (n) cyc();
   endtask

   task automatic burst(input logic [2:0] l, input logic t, input logic [8:0] c);
      len = l; ilv = t; scol = c; start = 1'b1;
      cyc();
      start = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";  idle(2);
      cur_req = "R11"; idle(2);
      cur_req = "R8";  stop = 1'b1; idle(2); stop = 1'b0;

      cur_req = "R4";
      burst(3'd1, 1'b0, 9'h1ED); idle(4);
      burst(3'd2, 1'b0, 9'h0A6); idle(6);
      burst(3'd3, 1'b0, 9'h1ED); idle(10);

      cur_req = "R5";
      burst(3'd2, 1'b1, 9'h0B5); idle(6);
      burst(3'd3, 1'b1, 9'h0B5); idle(10);
      burst(3'd3, 1'b1, 9'h003); idle(10);

      cur_req = "R7";
      burst(3'd0, 1'b0, 9'h155); idle(3);

      cur_req = "R12";
      burst(3'd5, 1'b1, 9'h0F0); idle(3);
      burst(3'd4, 1'b0, 9'h0F7); idle(2);
      burst(3'd6, 1'b0, 9'h1FF); idle(2);

      cur_req = "R6";
      burst(3'd7, 1'b1, 9'h1FC); idle(12);
      cur_req = "R8";
      stop = 1'b1; cyc(); stop = 1'b0; idle(3);
      burst(3'd3, 1'b0, 9'h010); idle(3);
      stop = 1'b1; cyc(); stop = 1'b0; idle(3);

      cur_req = "R9";
      burst(3'd3, 1'b0, 9'h020); idle(3);
      burst(3'd2, 1'b1, 9'h107); idle(2);
      len = 3'd1; ilv = 1'b0; scol = 9'h1C1; start = 1'b1; stop = 1'b1;
      cyc();
      start = 1'b0; stop = 1'b0; idle(4);

      cur_req = "R2";
      for (int k = 0; k < 6; k++) begin
         len = 3'(k % 4); ilv = k[0]; scol = 9'(k * 37 + 5); start = 1'b1;
         cyc();
      end
      start = 1'b0; idle(9);

      cur_req = "R10";
      burst(3'd3, 1'b0, 9'h044);
      len = 3'd0; ilv = 1'b1; idle(10);

      cur_req = "R3";
      burst(3'd2, 1'b0, 9'h030); idle(3);
      burst(3'd1, 1'b1, 9'h0C3); idle(4);
      burst(3'd2, 1'b1, 9'h0C3); idle(6);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule